// File: doc/BRIEF.md
# Flash Erase Block Selector

This block holds the erase selection for an on-chip flash array. Two byte-wide registers sit on a simple single-cycle register bus. The low register covers blocks 0 to 7 and the high register covers blocks 8 to 15. Software writes a single 1 into one of them to name the one block that the flash controller may erase. Every block whose bit is 0 stays protected. The block passes the combined selection to the array controller as a registered 16-bit one-hot erase-enable vector.

The selection is guarded in several ways:
- Any write that would leave two or more bits set across both registers wipes the whole selection.
- A system reset, either standby mode, or a low level on the program-enable pin clears everything.
- When the pin is high but the software program-enable bit is off, the low register is held at zero. In the high register only bit 0 is held at zero.
- The top bits of the high register are reserved on smaller parts. A parameter sets how many of them there are.
- While the flash is switched off, reads return zero and writes are dropped.

Top module: `flash_erase_sel`

## Requirements
- R1: After reset, and on every clock edge while `standby` is 1, both registers and `erase_en` are 0x00/0x0000.
- R2: On every clock edge while `prog_pin_en` is 0, both registers are cleared to 0x00, and any write on that edge is lost.
- R3: While `prog_pin_en` is 1 and `sw_prog_en` is 0, each edge clears the low register and bit 0 of the high register.
- R4: In the state of R3, bits 7..1 of the high register keep their value, and writes to them still take effect.
- R5: With the flash on and both enables set, a write with `wr_stb`=1 loads `wr_data` into the register chosen by `reg_sel` on that clock edge. `reg_sel`=0 selects the low register and `reg_sel`=1 the high one. `rd_data` shows the chosen register in the same cycle, combinationally.
- R6: If a write would leave more than one bit set across the 16 bits {high, low}, both registers become 0x00 on that edge. The combined value never has more than one bit set.
- R7: While `flash_on` is 0, `rd_data` reads 0x00 and writes leave both registers unchanged.
- R8: The top `HI_RSVD` bits of the high register (default 4, so bits 7..4) always read 0, and any 1 written to them is dropped.
- R9: `erase_en` equals {high register, low register} as it stood one clock earlier, with the high register in bits 15..8.
- R10: A write changes only the addressed register, unless the R6 guard clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 low byte, 1 high byte |
| wr_stb | input | 1 | Write strobe, single cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational |
| prog_pin_en | input | 1 | Level of the flash program-enable pin |
| sw_prog_en | input | 1 | Software program-enable bit |
| standby | input | 1 | Hardware or software standby active |
| flash_on | input | 1 | On-chip flash enabled |
| erase_en | output | 16 | One-hot erase enable to the array controller |

## Verification
The register state changes on the same edge that samples a write or a protection condition. Read data follows the register select combinationally, so a written value can be read back one cycle after the write. `erase_en` has one more register stage and changes one edge later still. The bench drives inputs on the falling edge and samples 1 ns after a rising edge. It reads both registers back after the write edge and checks `erase_en` after the following edge, so each result is compared in the cycle where it is first due.

// File: rtl/fes_pkg.sv
package fes_pkg;

  // Number of set bits in a vector of up to 32 bits
  function automatic int unsigned bit_count(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  // True when more than one bit is set
  function automatic logic multi_hot(input logic [31:0] v);
    return bit_count(v) > 1;
  endfunction

  // Writable-bit mask of the upper register, given its reserved top bits
  function automatic logic [7:0] upper_mask(input int unsigned rsvd);
    return 8'hFF >> rsvd;
  endfunction

endpackage

// File: rtl/fes_wr_path.sv
// Merges a bus write into the current selection, then applies the reserved mask and the protection rules.
module fes_wr_path #(
  parameter int REG_W   = 8,
  parameter int HI_RSVD = 4
) (
  input  logic [REG_W-1:0] cur_lo,
  input  logic [REG_W-1:0] cur_hi,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [REG_W-1:0] wdata,
  input  logic             pin_en,
  input  logic             sw_en,
  input  logic             stby,
  output logic [REG_W-1:0] cand_lo,
  output logic [REG_W-1:0] cand_hi
);
  localparam logic [REG_W-1:0] HI_MASK = REG_W'({REG_W{1'b1}} >> HI_RSVD);

  logic [REG_W-1:0] lo_w, hi_w;

  always_comb begin
    lo_w = wr_lo ? wdata : cur_lo;
    hi_w = (wr_hi ? wdata : cur_hi) & HI_MASK;
    if (stby || !pin_en) begin
      cand_lo = '0;
      cand_hi = '0;
    end else if (!sw_en) begin
      cand_lo = '0;
      cand_hi = {hi_w[REG_W-1:1], 1'b0};
    end else begin
      cand_lo = lo_w;
      cand_hi = hi_w;
    end
  end
endmodule

// File: rtl/fes_onehot_guard.sv
// Clears the whole selection when a write leaves more than one bit set.
module fes_onehot_guard #(
  parameter int W = 16
) (
  input  logic [W-1:0] cand,
  input  logic         any_wr,
  output logic [W-1:0] nxt,
  output logic         trip
);
  import fes_pkg::*;

  assign trip = any_wr && multi_hot(32'(cand));
  assign nxt  = trip ? '0 : cand;
endmodule

// File: rtl/fes_out_reg.sv
// Register stage for the erase-enable vector.
module fes_out_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/flash_erase_sel.sv
module flash_erase_sel #(
  parameter int REG_W   = 8,
  parameter int HI_RSVD = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_sel,
  input  logic               wr_stb,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  input  logic               prog_pin_en,
  input  logic               sw_prog_en,
  input  logic               standby,
  input  logic               flash_on,
  output logic [2*REG_W-1:0] erase_en
);
  localparam int SEL_W = 2 * REG_W;

  logic [REG_W-1:0] lo_q, hi_q;
  logic [REG_W-1:0] cand_lo, cand_hi;
  logic [SEL_W-1:0] sel_nxt;
  logic             wr_lo, wr_hi, wr_any, guard_trip;

  // Named write events, also watched by the checker
  assign wr_lo  = wr_stb && flash_on && !reg_sel;
  assign wr_hi  = wr_stb && flash_on &&  reg_sel;
  assign wr_any = wr_lo || wr_hi;

  fes_wr_path #(.REG_W(REG_W), .HI_RSVD(HI_RSVD)) u_path (
    .cur_lo (lo_q),
    .cur_hi (hi_q),
    .wr_lo  (wr_lo),
    .wr_hi  (wr_hi),
    .wdata  (wr_data),
    .pin_en (prog_pin_en),
    .sw_en  (sw_prog_en),
    .stby   (standby),
    .cand_lo(cand_lo),
    .cand_hi(cand_hi)
  );

  fes_onehot_guard #(.W(SEL_W)) u_guard (
    .cand  ({cand_hi, cand_lo}),
    .any_wr(wr_any),
    .nxt   (sel_nxt),
    .trip  (guard_trip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= sel_nxt[REG_W-1:0];
      hi_q <= sel_nxt[SEL_W-1:REG_W];
    end
  end

  assign rd_data = !flash_on ? '0 : (reg_sel ? hi_q : lo_q);

  fes_out_reg #(.W(SEL_W)) u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({hi_q, lo_q}),
    .q    (erase_en)
  );
endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
  parameter int REG_W   = 8,
  parameter int HI_RSVD = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_sel,
  input logic               wr_stb,
  input logic [REG_W-1:0]   rd_data,
  input logic               prog_pin_en,
  input logic               sw_prog_en,
  input logic               standby,
  input logic               flash_on,
  input logic [2*REG_W-1:0] erase_en,
  input logic [REG_W-1:0]   lo_q,
  input logic [REG_W-1:0]   hi_q,
  input logic               guard_trip
);
  localparam logic [REG_W-1:0] RSVD_BITS = ~REG_W'({REG_W{1'b1}} >> HI_RSVD);

  a_r1_standby_clears: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (lo_q == '0 && hi_q == '0));

  a_r2_pin_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_pin_en |=> (lo_q == '0 && hi_q == '0));

  a_r3_sw_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_pin_en && !sw_prog_en) |=> (lo_q == '0 && !hi_q[0]));

  a_r4_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_pin_en && !sw_prog_en && !standby && !(wr_stb && flash_on && reg_sel))
      |=> hi_q[REG_W-1:1] == $past(hi_q[REG_W-1:1]));

  a_r6_guard_clears: assert property (@(posedge clk) disable iff (!rst_n)
    guard_trip |=> (lo_q == '0 && hi_q == '0));

  a_r6_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hi_q, lo_q}) <= 1);

  a_r7_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_on |-> rd_data == '0);

  a_r7_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_on && prog_pin_en && sw_prog_en && !standby)
      |=> ($stable(lo_q) && $stable(hi_q)));

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q & RSVD_BITS) == '0);

  a_r9_output_lag: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en == $past({hi_q, lo_q}));
endmodule

bind flash_erase_sel fes_checker #(.REG_W(REG_W), .HI_RSVD(HI_RSVD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_sel    (reg_sel),
  .wr_stb     (wr_stb),
  .rd_data    (rd_data),
  .prog_pin_en(prog_pin_en),
  .sw_prog_en (sw_prog_en),
  .standby    (standby),
  .flash_on   (flash_on),
  .erase_en   (erase_en),
  .lo_q       (lo_q),
  .hi_q       (hi_q),
  .guard_trip (guard_trip)
);

// File: tb/tb_flash_erase_sel.sv
module tb_flash_erase_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        wr_stb = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        prog_pin_en = 1'b1;
  logic        sw_prog_en = 1'b1;
  logic        standby = 1'b0;
  logic        flash_on = 1'b1;
  logic [15:0] erase_en;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;   // 125 MHz

  flash_erase_sel dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_data(rd_data), .prog_pin_en(prog_pin_en),
    .sw_prog_en(sw_prog_en), .standby(standby), .flash_on(flash_on),
    .erase_en(erase_en)
  );

  // {reg_sel, wdata, pin, sw, exp_lo, exp_hi}, default 4 reserved upper bits
  typedef struct packed {
    logic       sel;
    logic [7:0] wd;
    logic       pin;
    logic       sw;
    logic [7:0] lo;
    logic [7:0] hi;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h01, 1'b1, 1'b1, 8'h01, 8'h00},  // R5 low load
    '{1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00},  // R10 zero clears
    '{1'b1, 8'h04, 1'b1, 1'b1, 8'h00, 8'h04},  // R5 high load
    '{1'b0, 8'h80, 1'b1, 1'b1, 8'h00, 8'h00},  // R6 across bytes
    '{1'b1, 8'h30, 1'b1, 1'b1, 8'h00, 8'h00},  // R8 reserved dropped
    '{1'b1, 8'h18, 1'b1, 1'b1, 8'h00, 8'h08},  // R8 mixed
    '{1'b1, 8'h03, 1'b1, 1'b1, 8'h00, 8'h00},  // R6 within byte
    '{1'b0, 8'h20, 1'b1, 1'b1, 8'h20, 8'h00},  // R10
    '{1'b0, 8'h60, 1'b1, 1'b1, 8'h00, 8'h00},  // R6
    '{1'b1, 8'h01, 1'b1, 1'b0, 8'h00, 8'h00},  // R3 bit0 forced
    '{1'b1, 8'h02, 1'b1, 1'b0, 8'h00, 8'h02},  // R4 upper writable
    '{1'b0, 8'h10, 1'b1, 1'b0, 8'h00, 8'h02},  // R3/R4 low held, upper kept
    '{1'b1, 8'h02, 1'b0, 1'b1, 8'h00, 8'h00},  // R2 pin low
    '{1'b1, 8'h01, 1'b1, 1'b1, 8'h00, 8'h01}   // R5
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Read both registers through the bus, combinationally
  task automatic rd_both(output logic [7:0] lo, output logic [7:0] hi);
    reg_sel = 1'b0; #1 lo = rd_data;
    reg_sel = 1'b1; #1 hi = rd_data;
  endtask

  task automatic bus_wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; wr_data = d; wr_stb = 1'b1;
    @(posedge clk); #1;
    wr_stb = 1'b0;
  endtask

  logic [7:0] lo, hi;

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rd_both(lo, hi);
    chk("R1 reset regs", {hi, lo}, 16'h0000);
    chk("R1 reset erase_en", erase_en, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    // Table walk: R2..R6, R8..R10
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      prog_pin_en = VECS[i].pin;
      sw_prog_en  = VECS[i].sw;
      bus_wr(VECS[i].sel, VECS[i].wd);
      rd_both(lo, hi);
      chk($sformatf("R5/R6 vec%0d regs", i), {hi, lo}, {VECS[i].hi, VECS[i].lo});
      @(posedge clk); #1;
      chk($sformatf("R9 vec%0d erase_en", i), erase_en, {VECS[i].hi, VECS[i].lo});
    end

    // R7: flash off, read zero, write dropped (high reg holds 0x01)
    @(negedge clk);
    prog_pin_en = 1'b1; sw_prog_en = 1'b1; flash_on = 1'b0;
    rd_both(lo, hi);
    chk("R7 read zero", {hi, lo}, 16'h0000);
    bus_wr(1'b1, 8'h04);
    bus_wr(1'b0, 8'h00);
    @(negedge clk); flash_on = 1'b1;
    rd_both(lo, hi);
    chk("R7 write dropped", {hi, lo}, 16'h0100);

    // R3 without a write: sw off clears low and high bit 0
    bus_wr(1'b1, 8'h00);
    bus_wr(1'b0, 8'h08);
    rd_both(lo, hi);
    chk("R3 setup", {hi, lo}, 16'h0008);
    @(negedge clk); sw_prog_en = 1'b0;
    @(posedge clk); #1;
    rd_both(lo, hi);
    chk("R3 low cleared", {hi, lo}, 16'h0000);
    @(negedge clk); sw_prog_en = 1'b1;
    bus_wr(1'b1, 8'h01);
    @(negedge clk); sw_prog_en = 1'b0;
    @(posedge clk); #1;
    rd_both(lo, hi);
    chk("R3 high bit0 cleared", {hi, lo}, 16'h0000);

    // R1: standby clears
    @(negedge clk); sw_prog_en = 1'b1;
    bus_wr(1'b1, 8'h08);
    @(negedge clk); standby = 1'b1;
    @(posedge clk); #1;
    rd_both(lo, hi);
    chk("R1 standby clears", {hi, lo}, 16'h0000);
    bus_wr(1'b0, 8'h02);
    rd_both(lo, hi);
    chk("R1 write in standby lost", {hi, lo}, 16'h0000);
    @(negedge clk); standby = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R1/R9 erase_en after standby", erase_en, 16'h0000);

    // R1: asynchronous reset mid-run
    bus_wr(1'b0, 8'h40);
    @(negedge clk); rst_n = 1'b0;
    #1;
    rd_both(lo, hi);
    chk("R1 async reset regs", {hi, lo}, 16'h0000);
    chk("R1 async reset erase_en", erase_en, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule